// File: doc/BRIEF.md
# Serial EEPROM Slave on a Two-Wire Bus

This block answers on an I2C bus as a byte-addressed serial EEPROM. It watches oversampled copies of SCL and SDA in the system clock domain, finds start and stop conditions, and takes in a device select byte, a two-byte memory address and data bytes. Each byte gets an acknowledge, or none, on the ninth clock. SDA is driven only as an open-drain pull-down enable (`sda_oe` high pulls the line low).

Written data bytes collect in a one-page staging buffer of `PAGE_BYTES` bytes. A stop that follows at least one accepted data byte starts an internal write cycle of `WRITE_CYCLES` system clocks. During that cycle the staged page is copied into the internal array and the bus is ignored completely. A master therefore polls with a device select byte until it is acknowledged again. Reads return bytes from the current address pointer, either directly or after a dummy write that loads the pointer, and keep going byte after byte until the master withholds its acknowledge.

The array holds `2**ADDR_W` bytes. A product build sets `ADDR_W` to 13 (8 Kbytes). The default of 11 keeps elaboration small. `WRITE_CYCLES` must be at least `PAGE_BYTES`.

Top module: `i2c_eeprom_slave`

## Requirements
- R1: Bus activity counts only after a start (SDA falls while SCL is high). Bytes clocked before any start get no acknowledge. A stop (SDA rises while SCL is high) returns the slave to idle with SDA released.
- R2: A device select byte is accepted only when its upper seven bits equal 1010 followed by the `CHIP_SEL` parameter (bit 0 is R/W, 1 = read). On a mismatch the slave does not acknowledge, and it stays silent until the next start.
- R3: The slave acknowledges on the ninth SCL pulse by pulling SDA low for every accepted byte: device select, both address bytes, and data bytes while writes are enabled. It begins driving SDA only while SCL is low.
- R4: After a write device select, the memory address arrives high byte first. Address bits above `ADDR_W` are ignored.
- R5: Data bytes of a write are staged at successive offsets within the addressed page. The offset wraps from the page's last byte to its first, and bytes beyond one page overwrite earlier ones.
- R6: A stop after one or more accepted data bytes starts a write cycle of exactly `WRITE_CYCLES` clocks, which commits the staged bytes to the array. A stop after only the address bytes starts no write cycle.
- R7: During the write cycle, starts and device select bytes get no acknowledge. Once the cycle ends, a device select is acknowledged again.
- R8: While `wc_i` is high, data bytes are not acknowledged and the array keeps its contents. No write cycle starts, so the next device select is acknowledged at once.
- R9: A read device select with no preceding address returns the byte at the current pointer, which is one past the last byte read.
- R10: A write device select and two address bytes, then a repeated start and a read device select, return data from the given address.
- R11: In a read, the pointer advances after each byte and wraps from the last array location to 0. When the master does not acknowledge, the slave releases SDA and sends nothing further.
- R12: After reset, SDA is released and the slave is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level (wired-AND of all drivers) |
| wc_i | input | 1 | Write control; high blocks writes |
| sda_oe | output | 1 | High pulls SDA low (open-drain enable) |

## Verification
The hardest state to reach is the internal write cycle, together with the page-offset wrap inside it. It exists only after a full start, select, address, data and stop sequence, and its end shows at the ports only as a change in whether a device select is acknowledged. The bench drives complete bus transactions bit by bit through a modelled wired-AND line. It polls immediately after each committing stop, so the first poll lands inside the cycle, and it polls again until an acknowledge appears. Page wrap and overrun are reached with writes that start near the end of a page and writes longer than one page, followed by sequential read-back. Random addresses and lengths then go through the same path.

// File: rtl/i2c_ee_pkg.sv
package i2c_ee_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DEV,
    ST_AHI,
    ST_ALO,
    ST_WDAT,
    ST_RDAT,
    ST_BUSY
  } ee_state_e;
endpackage

// File: rtl/i2c_ee_linemon.sv
// Synchronises the two bus lines and flags start, stop and SCL edges.
module i2c_ee_linemon (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic start_o,
  output logic stop_o,
  output logic rise_o,
  output logic fall_o
);
  // [0] first stage, [1] synchronised, [2] previous synchronised
  logic [2:0] scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 3'b111;
      sda_q <= 3'b111;
    end else begin
      scl_q <= {scl_q[1:0], scl_i};
      sda_q <= {sda_q[1:0], sda_i};
    end
  end

  assign scl_s   = scl_q[1];
  assign sda_s   = sda_q[1];
  assign start_o = scl_q[1] & scl_q[2] & sda_q[2] & ~sda_q[1];
  assign stop_o  = scl_q[1] & scl_q[2] & ~sda_q[2] & sda_q[1];
  assign rise_o  = scl_q[1] & ~scl_q[2];
  assign fall_o  = ~scl_q[1] & scl_q[2];
endmodule

// File: rtl/i2c_ee_pagebuf.sv
// One page of staged write data with a valid flag per byte.
module i2c_ee_pagebuf #(
  parameter  int PAGE_BYTES = 32,
  localparam int OFF_W      = $clog2(PAGE_BYTES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             wr_en,
  input  logic [OFF_W-1:0] wr_off,
  input  logic [7:0]       wr_data,
  input  logic [OFF_W-1:0] rd_off,
  output logic [7:0]       rd_data,
  output logic             rd_valid
);
  logic [PAGE_BYTES-1:0] vld;
  logic [7:0]            dat [PAGE_BYTES];

  for (genvar g = 0; g < PAGE_BYTES; g++) begin : g_ent
    logic       v_q;
    logic [7:0] d_q;
    logic       hit;
    assign hit = wr_en && (wr_off == OFF_W'(g));

    always_ff @(posedge clk) begin
      if (hit) d_q <= wr_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   v_q <= 1'b0;
      else if (clr) v_q <= 1'b0;
      else if (hit) v_q <= 1'b1;
    end

    assign vld[g] = v_q;
    assign dat[g] = d_q;
  end

  assign rd_data  = dat[rd_off];
  assign rd_valid = vld[rd_off];
endmodule

// File: rtl/i2c_ee_array.sv
// Byte array with one synchronous write port and one combinational read port.
module i2c_ee_array #(
  parameter  int ADDR_W = 11,
  localparam int DEPTH  = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [7:0]        wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [7:0]        rdata
);
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/i2c_eeprom_slave.sv
module i2c_eeprom_slave
  import i2c_ee_pkg::*;
#(
  parameter int         ADDR_W       = 11,
  parameter int         PAGE_BYTES   = 32,
  parameter int         WRITE_CYCLES = 400,
  parameter logic [2:0] CHIP_SEL     = 3'b000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  input  logic wc_i,
  output logic sda_oe
);
  localparam int OFF_W = $clog2(PAGE_BYTES);
  localparam int TMR_W = $clog2(WRITE_CYCLES + 1);
  localparam logic [OFF_W:0] CIDX_END = (OFF_W+1)'(PAGE_BYTES);

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_q;
  logic       rst_i_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_q <= 2'b00;
    else        rst_q <= {rst_q[0], 1'b1};
  end
  assign rst_i_n = rst_q[1];

  logic scl_s, sda_s, start_ev, stop_ev, rise_ev, fall_ev;
  i2c_ee_linemon u_mon (
    .clk(clk), .rst_n(rst_i_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .start_o(start_ev), .stop_o(stop_ev),
    .rise_o(rise_ev), .fall_o(fall_ev)
  );

  ee_state_e         st, st_n;
  logic [3:0]        bitcnt, bit_n;
  logic [7:0]        shreg, sh_n, txreg, tx_n, ahi, ahi_n;
  logic [ADDR_W-1:0] ptr, ptr_n;
  logic              go, go_n, oe_n, pend, pend_n, mack, mack_n;
  logic [TMR_W-1:0]  tmr, tmr_n;
  logic [OFF_W:0]    cidx, cidx_n;
  logic              buf_clr, buf_we;

  logic [15:0] addr16;
  logic        unused_addr;
  assign addr16      = {ahi, shreg};
  assign unused_addr = ^addr16[15:ADDR_W];

  logic [7:0] rdata, bdata;
  logic       bvalid, busy, arr_we;
  assign busy   = (st == ST_BUSY);
  assign arr_we = busy && (cidx != CIDX_END) && bvalid;

  i2c_ee_pagebuf #(.PAGE_BYTES(PAGE_BYTES)) u_buf (
    .clk(clk), .rst_n(rst_i_n), .clr(buf_clr), .wr_en(buf_we),
    .wr_off(ptr[OFF_W-1:0]), .wr_data(shreg),
    .rd_off(cidx[OFF_W-1:0]), .rd_data(bdata), .rd_valid(bvalid)
  );

  i2c_ee_array #(.ADDR_W(ADDR_W)) u_arr (
    .clk(clk), .we(arr_we), .waddr({ptr[ADDR_W-1:OFF_W], cidx[OFF_W-1:0]}),
    .wdata(bdata), .raddr(ptr), .rdata(rdata)
  );

  // next-state logic
  always_comb begin
    st_n = st;  bit_n = bitcnt; sh_n = shreg; tx_n = txreg; ahi_n = ahi;
    ptr_n = ptr; go_n = go; oe_n = sda_oe; pend_n = pend; mack_n = mack;
    tmr_n = tmr; cidx_n = cidx; buf_clr = 1'b0; buf_we = 1'b0;
    if (st == ST_BUSY) begin
      if (cidx != CIDX_END) cidx_n = cidx + 1'b1;
      if (tmr == '0) st_n = ST_IDLE;
      else           tmr_n = tmr - 1'b1;
    end else if (start_ev) begin
      st_n = ST_DEV; bit_n = 4'd0; oe_n = 1'b0; pend_n = 1'b0;
    end else if (stop_ev) begin
      oe_n = 1'b0; bit_n = 4'd0;
      if (pend) begin
        st_n = ST_BUSY; tmr_n = TMR_W'(WRITE_CYCLES - 1); cidx_n = '0; pend_n = 1'b0;
      end else begin
        st_n = ST_IDLE;
      end
    end else if (st != ST_IDLE) begin
      if (rise_ev) begin
        if (bitcnt != 4'd9) bit_n  = bitcnt + 4'd1;
        if (bitcnt < 4'd8)  sh_n   = {shreg[6:0], sda_s};
        if (bitcnt == 4'd8) mack_n = sda_s;
      end else if (fall_ev) begin
        if (st == ST_RDAT) begin
          if (bitcnt != 4'd0 && bitcnt < 4'd8) begin
            tx_n = {txreg[6:0], 1'b0}; oe_n = ~txreg[6];
          end else if (bitcnt == 4'd8) begin
            oe_n = 1'b0; ptr_n = ptr + 1'b1;
          end else if (bitcnt == 4'd9) begin
            if (!mack) begin tx_n = rdata; oe_n = ~rdata[7]; bit_n = 4'd0; end
            else       st_n = ST_IDLE;
          end
        end else if (bitcnt == 4'd8) begin
          go_n = 1'b0;
          case (st)
            ST_DEV:  go_n = (shreg[7:1] == {4'b1010, CHIP_SEL});
            ST_AHI:  begin go_n = 1'b1; ahi_n = shreg; end
            ST_ALO:  begin go_n = 1'b1; ptr_n = addr16[ADDR_W-1:0]; buf_clr = 1'b1; end
            ST_WDAT: if (!wc_i) begin
              go_n = 1'b1; buf_we = 1'b1; pend_n = 1'b1;
              ptr_n = {ptr[ADDR_W-1:OFF_W], ptr[OFF_W-1:0] + 1'b1};
            end
            default: go_n = 1'b0;
          endcase
          oe_n = go_n;
        end else if (bitcnt == 4'd9) begin
          oe_n = 1'b0; bit_n = 4'd0;
          if (!go) st_n = ST_IDLE;
          else begin
            case (st)
              ST_DEV: if (shreg[0]) begin
                st_n = ST_RDAT; tx_n = rdata; oe_n = ~rdata[7];
              end else begin
                st_n = ST_AHI;
              end
              ST_AHI:  st_n = ST_ALO;
              ST_ALO:  st_n = ST_WDAT;
              default: st_n = st;
            endcase
          end
        end
      end
    end
  end

  // state registers
  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      st <= ST_IDLE; bitcnt <= 4'd0; shreg <= 8'h00; txreg <= 8'h00; ahi <= 8'h00;
      ptr <= '0; go <= 1'b0; sda_oe <= 1'b0; pend <= 1'b0; mack <= 1'b1;
      tmr <= '0; cidx <= CIDX_END;
    end else begin
      st <= st_n; bitcnt <= bit_n; shreg <= sh_n; txreg <= tx_n; ahi <= ahi_n;
      ptr <= ptr_n; go <= go_n; sda_oe <= oe_n; pend <= pend_n; mack <= mack_n;
      tmr <= tmr_n; cidx <= cidx_n;
    end
  end
endmodule

// File: rtl/i2c_ee_checker.sv
module i2c_ee_checker #(
  parameter int PAGE_BYTES   = 32,
  parameter int WRITE_CYCLES = 400
) (
  input logic clk,
  input logic rst_n,
  input logic busy,
  input logic arr_we,
  input logic stop_ev,
  input logic scl_s,
  input logic sda_oe
);
  int unsigned wcnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    wcnt <= 0;
    else if (busy) wcnt <= wcnt + 1;
    else           wcnt <= 0;
  end

  // R7: nothing is driven on the bus while the write cycle runs
  assert_busy_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !sda_oe);

  // R3: the slave starts pulling SDA low only while SCL is low
  assert_drive_scl_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !scl_s);

  // R6: the write cycle lasts exactly WRITE_CYCLES clocks
  assert_write_len_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (wcnt == WRITE_CYCLES));

  // R6: array commits fall inside the first page-length of the write cycle
  assert_commit_window_R6: assert property (@(posedge clk) disable iff (!rst_n)
    arr_we |-> (busy && wcnt < PAGE_BYTES));

  // R1: a stop leaves SDA released
  assert_stop_release_R1: assert property (@(posedge clk) disable iff (!rst_n)
    stop_ev |=> !sda_oe);
endmodule

bind i2c_eeprom_slave i2c_ee_checker #(
  .PAGE_BYTES(PAGE_BYTES), .WRITE_CYCLES(WRITE_CYCLES)
) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .arr_we(arr_we),
  .stop_ev(stop_ev), .scl_s(scl_s), .sda_oe(sda_oe)
);

// File: tb/i2c_eeprom_slave_test.sv
`timescale 1ns/1ps
module i2c_eeprom_slave_test;
  localparam int AW = 11;
  localparam int DEPTH = 1 << AW;
  localparam int H = 12;  // clocks per SCL half period
  localparam int Q = 6;

  logic clk, rst_n, scl, m_sda, wc;
  logic sda_oe;
  wire  sda_line = m_sda & ~sda_oe;

  i2c_eeprom_slave uut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line), .wc_i(wc), .sda_oe(sda_oe)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  int n_chk = 0, n_bad = 0;
  logic [7:0] model [DEPTH];
  bit         known [DEPTH];
  logic [7:0] wbuf [64];
  logic [7:0] rbuf [64];

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic int in_page(input int base, input int k);
    return (base & ~31) | ((base + k) & 31);
  endfunction

  task automatic bus_start();          // from idle: SCL and SDA high
    m_sda = 1'b0; wt(H); scl = 1'b0;
  endtask
  task automatic bus_rstart();         // SCL low
    wt(Q); m_sda = 1'b1; wt(Q); scl = 1'b1; wt(H); m_sda = 1'b0; wt(H); scl = 1'b0;
  endtask
  task automatic bus_stop();           // SCL low
    wt(Q); m_sda = 1'b0; wt(Q); scl = 1'b1; wt(H); m_sda = 1'b1; wt(H);
  endtask

  task automatic send_byte(input logic [7:0] b, output bit ak);
    for (int i = 7; i >= 0; i--) begin
      wt(Q); m_sda = b[i]; wt(Q); scl = 1'b1; wt(H); scl = 1'b0;
    end
    wt(Q); m_sda = 1'b1; wt(Q); scl = 1'b1; wt(H/2); ak = ~sda_line; wt(H/2); scl = 1'b0;
  endtask

  task automatic recv_byte(input bit nack, output logic [7:0] d);
    for (int i = 0; i < 8; i++) begin
      wt(Q); m_sda = 1'b1; wt(Q); scl = 1'b1; wt(H/2); d = {d[6:0], sda_line}; wt(H/2); scl = 1'b0;
    end
    wt(Q); m_sda = nack; wt(Q); scl = 1'b1; wt(H); scl = 1'b0;
  endtask

  // write n bytes of wbuf at a16; returns header acks and count of acked data
  task automatic write_seq(input logic [15:0] a16, input int n, output bit hdr_ok, output int nacked);
    bit ak;
    bus_start();
    send_byte(8'hA0, ak); hdr_ok = ak;
    send_byte(a16[15:8], ak); hdr_ok &= ak;
    send_byte(a16[7:0], ak);  hdr_ok &= ak;
    nacked = 0;
    for (int i = 0; i < n; i++) begin
      send_byte(wbuf[i], ak);
      if (ak) begin
        model[in_page(int'(a16) % DEPTH, i)] = wbuf[i];
        known[in_page(int'(a16) % DEPTH, i)] = 1'b1;
        nacked++;
      end
    end
    bus_stop();
  endtask

  task automatic poll(output int polls, output bit first_ak);
    bit ak;
    polls = 0;
    do begin
      bus_start(); send_byte(8'hA0, ak); bus_stop();
      if (polls == 0) first_ak = ak;
      polls++;
    end while (!ak && polls < 40);
  endtask

  task automatic rand_read(input logic [15:0] a16, input int n, output bit ok);
    bit ak;
    bus_start();
    send_byte(8'hA0, ak); ok = ak;
    send_byte(a16[15:8], ak); ok &= ak;
    send_byte(a16[7:0], ak);  ok &= ak;
    bus_rstart();
    send_byte(8'hA1, ak); ok &= ak;
    for (int i = 0; i < n; i++) recv_byte(i == n-1, rbuf[i]);
    bus_stop();
  endtask

  task automatic check_read(input int a, input int n, input string req);
    for (int i = 0; i < n; i++) begin
      int ad = (a + i) % DEPTH;
      if (known[ad]) chk(rbuf[i] === model[ad], req, rbuf[i], model[ad]);
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_bad++;
    $display("FAIL R-watchdog actual=%0d expected=%0d", 190000, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    bit ak, hok, fak, rok;
    int na, np;
    void'($urandom(32'h1A2B3C4D));
    for (int i = 0; i < DEPTH; i++) known[i] = 1'b0;
    scl = 1'b1; m_sda = 1'b1; wc = 1'b0; rst_n = 1'b0;
    wt(5);
    chk(sda_oe == 1'b0, "R12 reset release", sda_oe, 0);
    rst_n = 1'b1; wt(5);
    chk(sda_oe == 1'b0, "R12 idle after reset", sda_oe, 0);

    // R1: clocking a valid select byte with no start
    scl = 1'b0;
    send_byte(8'hA0, ak);
    chk(!ak, "R1 no ack without start", ak, 0);
    bus_stop();

    // R2: wrong chip select, then silence
    bus_start(); send_byte(8'hA2, ak);
    chk(!ak, "R2 foreign select nacked", ak, 0);
    send_byte(8'h00, ak);
    chk(!ak, "R2 silent until start", ak, 0);
    bus_stop();

    // R3/R4/R5/R6/R7: page write with high address bits set (0xF840 -> 0x040)
    for (int i = 0; i < 8; i++) wbuf[i] = 8'h30 + 8'(i);
    write_seq(16'hF840, 8, hok, na);
    chk(hok, "R3 header acked", hok, 1);
    chk(na == 8, "R3 data acked", na, 8);
    poll(np, fak);
    chk(!fak, "R7 busy poll nacked", fak, 0);
    chk(np > 1 && np < 40, "R7 ack after write cycle", np, 2);
    rand_read(16'h0040, 4, rok);
    chk(rok, "R10 random read acks", rok, 1);
    check_read(16'h040, 4, "R4 R6 R10 read back");

    // R9: current address read continues at 0x044
    bus_start(); send_byte(8'hA1, ak); recv_byte(1'b1, rbuf[0]); bus_stop();
    chk(ak, "R9 current read select", ak, 1);
    chk(rbuf[0] === model[16'h044], "R9 current address data", rbuf[0], model[16'h044]);

    // R6: dummy write (address only) starts no write cycle
    bus_start(); send_byte(8'hA0, ak); send_byte(8'h00, ak); send_byte(8'h40, ak); bus_stop();
    bus_start(); send_byte(8'hA0, ak); bus_stop();
    chk(ak, "R6 no cycle after address-only write", ak, 1);

    // R5: write starting at offset 30 wraps inside page 0x100
    for (int i = 0; i < 6; i++) wbuf[i] = 8'hC0 + 8'(i);
    write_seq(16'h011E, 6, hok, na);
    poll(np, fak);
    rand_read(16'h0100, 32, rok);
    chk(rbuf[0] === 8'hC2, "R5 wrap to page start", rbuf[0], 8'hC2);
    chk(rbuf[31] === 8'hC1, "R5 page end byte", rbuf[31], 8'hC1);

    // R5: 34 bytes into page 0x120, last two overwrite offsets 0 and 1
    for (int i = 0; i < 34; i++) wbuf[i] = 8'(i * 7 + 1);
    write_seq(16'h0120, 34, hok, na);
    poll(np, fak);
    rand_read(16'h0120, 32, rok);
    chk(rbuf[0] === wbuf[32], "R5 overrun overwrite", rbuf[0], wbuf[32]);
    check_read(16'h120, 32, "R5 overrun page");

    // R8: write control high
    wc = 1'b1;
    wbuf[0] = 8'h5A;
    write_seq(16'h0040, 1, hok, na);
    chk(na == 0, "R8 data nacked", na, 0);
    bus_start(); send_byte(8'hA0, ak); bus_stop();
    chk(ak, "R8 no write cycle", ak, 1);
    wc = 1'b0;
    rand_read(16'h0040, 1, rok);
    chk(rbuf[0] === model[16'h040], "R8 array unchanged", rbuf[0], model[16'h040]);

    // R11: sequential read wraps from last location to 0
    for (int i = 0; i < 32; i++) wbuf[i] = 8'($urandom);
    write_seq(16'h07E0, 32, hok, na); poll(np, fak);
    for (int i = 0; i < 4; i++) wbuf[i] = 8'hE0 + 8'(i);
    write_seq(16'h0000, 4, hok, na); poll(np, fak);
    rand_read(16'h07FE, 4, rok);
    check_read(16'h7FE, 4, "R11 wrap read");
    chk(sda_oe == 1'b0, "R11 released after nack", sda_oe, 0);

    // random page writes with read-back
    for (int it = 0; it < 4; it++) begin
      int a = int'($urandom_range(DEPTH - 1));
      int n = int'($urandom_range(36, 1));
      for (int i = 0; i < n; i++) wbuf[i] = 8'($urandom);
      write_seq(16'(a), n, hok, na);
      chk(na == n, "R3 random data acked", na, n);
      poll(np, fak);
      chk(!fak, "R7 random busy poll", fak, 0);
      rand_read(16'(a & ~31), 32, rok);
      check_read(a & ~31, 32, "R5 R6 random read back");
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule